// File: doc/BRIEF.md
# Deferred-Write Store Buffer for a Data Cache

This block sits between a pipelined load/store unit and a write-back data cache whose tag array and data array take separate indices. The pipeline checks a store against the tag array only. If the check confirms the line, the store's word address, data and byte enables go into a small in-order buffer, so the store never writes the data array in its own slot. A tag miss is not buffered; it is reported to a miss handler outside this block.

Buffered entries retire into the data array, oldest first, on any cycle when no load is reading the array. Two conditions override a load: the buffer is full while a new store waits, or a flush is in progress. A load whose word matches buffered entries gets their bytes forwarded per byte lane, with the youngest entry winning. A store to the same word as the youngest entry is folded into that entry. The only stall is the one raised while the buffer is full.

Top module: `stbuf_top`

## Requirements
- R1: While `rst` is high at a rising edge, the buffer empties. After that edge, `buf_empty` is 1 and `ld_rvalid`, `miss_valid`, `st_stall` and `arr_wr_en` are 0.
- R2: A store with `st_tag_hit`=1 never writes the data array in its own cycle. The write happens only when its entry later reaches the head of the buffer. With an empty buffer, `arr_wr_en` is 0.
- R3: `arr_wr_en` is high in a cycle only if the buffer is non-empty and one of three holds: `ld_valid` is 0, `st_stall` is 1, or a flush is active. The written address, data and byte enables are those of the oldest entry, so writes reach the array in store order.
- R4: `ld_rvalid` rises one cycle after `ld_valid`. For each byte lane b, bits 8b+7..8b of `ld_rdata` come from the youngest buffered entry for that word whose byte enable bit b is set. If no such entry exists, they come from `arr_rdata`, which the array returns one cycle after the read request.
- R5: A load presented in the same cycle as a store sees the buffer as it stood before that store. The load is treated as older than the store.
- R6: A hit store is merged into the youngest entry under its byte enables, without taking a new slot, when two things hold: its word address equals that entry's address, and that entry is not being written to the array in the same cycle.
- R7: If a hit store cannot merge and the buffer holds DEPTH entries, `st_stall` is 1 that cycle and the store is not accepted. The oldest entry is written to the array that same cycle, even when `ld_valid` is 1.
- R8: A store with `st_tag_hit`=0 is never buffered. `miss_valid` is 1 in the next cycle, and `miss_addr` then holds the store's address.
- R9: A one-cycle pulse on `flush` forces one array write per cycle, regardless of loads, until the buffer is empty. `buf_empty` is 1 whenever no entry is held.
- R10: `st_stall` is never asserted while the buffer has a free slot, so stores and loads can issue every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented after its tag check |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables, bit b covers bits 8b+7..8b |
| st_tag_hit | input | 1 | Tag check result for the store |
| st_stall | output | 1 | Store not accepted, buffer full |
| miss_valid | output | 1 | Store tag miss reported to the miss handler |
| miss_addr | output | ADDR_W | Address of the missing store |
| ld_valid | input | 1 | Load reads the data array this cycle |
| ld_addr | input | ADDR_W | Load word address |
| ld_rvalid | output | 1 | Load result valid |
| ld_rdata | output | DATA_W | Load result after forwarding |
| arr_rd_en | output | 1 | Data array read enable |
| arr_rd_addr | output | ADDR_W | Data array read index |
| arr_rdata | input | DATA_W | Data array read data, one cycle after the request |
| arr_wr_en | output | 1 | Data array write enable |
| arr_wr_addr | output | ADDR_W | Data array write index |
| arr_wr_data | output | DATA_W | Data array write data |
| arr_wr_be | output | DATA_W/8 | Data array byte write enables |
| flush | input | 1 | Start draining the buffer to empty |
| buf_empty | output | 1 | No entry held |

## Verification
The stall, the array write and the array read request are due in the same cycle as the inputs that cause them. Load results and miss reports appear one rising edge later, and the empty flag shows the state left by the previous edge. The bench drives inputs just after a falling edge and samples 1 ns later. In that sample it compares the same-cycle outputs with what its queue model computes from the current inputs. It compares the one-cycle-late outputs with the values the model stored on the previous step. The model then advances its queue and array mirror, so every comparison lands on the cycle where the requirement says the value is due.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  // Default geometry shared by the block and its bench
  localparam int SB_ADDR_W = 8;   // word address width
  localparam int SB_DATA_W = 32;  // word width, multiple of 8
  localparam int SB_DEPTH  = 4;   // entries, power of two, at least 2
endpackage

// File: rtl/stbuf_fifo.sv
// Entry storage: circular queue with an in-place merge into the youngest slot,
// plus an age-ordered view (index 0 = oldest) for forwarding and draining.
module stbuf_fifo #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  logic                 merge,
  input  logic                 pop,
  input  logic [AW-1:0]        in_addr,
  input  logic [DW-1:0]        in_data,
  input  logic [DW/8-1:0]      in_be,
  output logic [$clog2(DEPTH):0] cnt,
  output logic [AW-1:0]        young_addr,
  output logic [AW-1:0]        ord_addr [DEPTH],
  output logic [DW-1:0]        ord_data [DEPTH],
  output logic [DW/8-1:0]      ord_be   [DEPTH]
);
  localparam int NB = DW / 8;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [NB-1:0] be_q   [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, yg_ptr;

  assign yg_ptr     = wr_ptr - PW'(1);
  assign young_addr = addr_q[yg_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      if (push) wr_ptr <= wr_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // Storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= in_addr;
      data_q[wr_ptr] <= in_data;
      be_q[wr_ptr]   <= in_be;
    end else if (merge) begin
      for (int b = 0; b < NB; b++)
        if (in_be[b]) data_q[yg_ptr][8*b +: 8] <= in_data[8*b +: 8];
      be_q[yg_ptr] <= be_q[yg_ptr] | in_be;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ord
    assign ord_addr[i] = addr_q[rd_ptr + PW'(i)];
    assign ord_data[i] = data_q[rd_ptr + PW'(i)];
    assign ord_be[i]   = be_q[rd_ptr + PW'(i)];
  end
endmodule

// File: rtl/stbuf_fwd.sv
// Per-byte forwarding: walk entries oldest to youngest so the youngest wins.
module stbuf_fwd #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic [AW-1:0]          ld_addr,
  input  logic [$clog2(DEPTH):0] cnt,
  input  logic [AW-1:0]          ord_addr [DEPTH],
  input  logic [DW-1:0]          ord_data [DEPTH],
  input  logic [DW/8-1:0]        ord_be   [DEPTH],
  output logic [DW-1:0]          fwd_data,
  output logic [DW/8-1:0]        fwd_be
);
  localparam int NB = DW / 8;
  localparam int CW = $clog2(DEPTH) + 1;

  always_comb begin
    fwd_data = '0;
    fwd_be   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt) && (ord_addr[i] == ld_addr)) begin
        for (int b = 0; b < NB; b++) begin
          if (ord_be[i][b]) begin
            fwd_data[8*b +: 8] = ord_data[i][8*b +: 8];
            fwd_be[b]          = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stbuf_ctrl.sv
// Accept/merge/drain decisions and the flush state.
module stbuf_ctrl #(
  parameter int AW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   st_valid,
  input  logic                   st_tag_hit,
  input  logic [AW-1:0]          st_addr,
  input  logic [AW-1:0]          young_addr,
  input  logic [$clog2(DEPTH):0] cnt,
  input  logic                   ld_valid,
  input  logic                   flush,
  output logic                   push,
  output logic                   merge,
  output logic                   pop,
  output logic                   stall,
  output logic                   flush_act
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic flush_q, hit, nonempty, full, single, drain_soft;
  logic [CW-1:0] cnt_after;

  always_comb begin
    hit        = st_valid & st_tag_hit;
    nonempty   = (cnt != '0);
    full       = (cnt == FULL_CNT);
    single     = (cnt == CW'(1));
    flush_act  = flush | flush_q;
    // loads own the array unless a flush is running
    drain_soft = nonempty & (~ld_valid | flush_act);
    merge      = hit & nonempty & (st_addr == young_addr) & ~(single & drain_soft);
    stall      = hit & full & ~merge;
    pop        = drain_soft | stall;
    push       = hit & ~merge & ~full;
    case ({push, pop})
      2'b10:   cnt_after = cnt + CW'(1);
      2'b01:   cnt_after = cnt - CW'(1);
      default: cnt_after = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= flush_act & (cnt_after != '0);
  end
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int ADDR_W = SB_ADDR_W,
  parameter int DATA_W = SB_DATA_W,
  parameter int DEPTH  = SB_DEPTH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                st_valid,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W/8-1:0] st_be,
  input  logic                st_tag_hit,
  output logic                st_stall,
  output logic                miss_valid,
  output logic [ADDR_W-1:0]   miss_addr,
  input  logic                ld_valid,
  input  logic [ADDR_W-1:0]   ld_addr,
  output logic                ld_rvalid,
  output logic [DATA_W-1:0]   ld_rdata,
  output logic                arr_rd_en,
  output logic [ADDR_W-1:0]   arr_rd_addr,
  input  logic [DATA_W-1:0]   arr_rdata,
  output logic                arr_wr_en,
  output logic [ADDR_W-1:0]   arr_wr_addr,
  output logic [DATA_W-1:0]   arr_wr_data,
  output logic [DATA_W/8-1:0] arr_wr_be,
  input  logic                flush,
  output logic                buf_empty
);
  localparam int NB = DATA_W / 8;
  localparam int CW = $clog2(DEPTH) + 1;

  logic              push, merge, pop, flush_act;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] young_addr;
  logic [ADDR_W-1:0] ord_addr [DEPTH];
  logic [DATA_W-1:0] ord_data [DEPTH];
  logic [NB-1:0]     ord_be   [DEPTH];
  logic [DATA_W-1:0] fwd_data, fwd_data_q;
  logic [NB-1:0]     fwd_be, fwd_be_q;

  stbuf_ctrl #(.AW(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
    .clk, .rst, .st_valid, .st_tag_hit, .st_addr,
    .young_addr, .cnt, .ld_valid, .flush,
    .push, .merge, .pop, .stall(st_stall), .flush_act
  );

  stbuf_fifo #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst, .push, .merge, .pop,
    .in_addr(st_addr), .in_data(st_data), .in_be(st_be),
    .cnt, .young_addr, .ord_addr, .ord_data, .ord_be
  );

  stbuf_fwd #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_fwd (
    .ld_addr, .cnt, .ord_addr, .ord_data, .ord_be, .fwd_data, .fwd_be
  );

  // Array side: loads read directly, the head entry drains
  assign arr_rd_en   = ld_valid;
  assign arr_rd_addr = ld_addr;
  assign arr_wr_en   = pop;
  assign arr_wr_addr = ord_addr[0];
  assign arr_wr_data = ord_data[0];
  assign arr_wr_be   = ord_be[0];
  assign buf_empty   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rvalid  <= 1'b0;
      miss_valid <= 1'b0;
    end else begin
      ld_rvalid  <= ld_valid;
      miss_valid <= st_valid & ~st_tag_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      fwd_data_q <= fwd_data;
      fwd_be_q   <= fwd_be;
    end
    if (st_valid & ~st_tag_hit) miss_addr <= st_addr;
  end

  always_comb begin
    for (int b = 0; b < NB; b++)
      ld_rdata[8*b +: 8] = fwd_be_q[b] ? fwd_data_q[8*b +: 8] : arr_rdata[8*b +: 8];
  end
endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              st_valid,
  input logic              st_tag_hit,
  input logic [ADDR_W-1:0] st_addr,
  input logic              st_stall,
  input logic              ld_valid,
  input logic              ld_rvalid,
  input logic              arr_wr_en,
  input logic              miss_valid,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              flush_act,
  input logic              buf_empty
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (buf_empty && !miss_valid && !ld_rvalid));

  a_r2_no_write_when_empty: assert property (@(posedge clk) disable iff (rst)
    buf_empty |-> !arr_wr_en);

  a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_en && ld_valid) |-> (st_stall || flush_act));

  a_r4_load_latency: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_rvalid);

  a_r7_stall_drains: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> (arr_wr_en && !buf_empty));

  a_r8_miss_report: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_tag_hit) |=> (miss_valid && miss_addr == $past(st_addr)));

  a_r9_flush_drains: assert property (@(posedge clk) disable iff (rst)
    (flush_act && !buf_empty) |-> arr_wr_en);
endmodule

bind stbuf_top stbuf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_tag_hit(st_tag_hit),
  .st_addr(st_addr), .st_stall(st_stall), .ld_valid(ld_valid),
  .ld_rvalid(ld_rvalid), .arr_wr_en(arr_wr_en), .miss_valid(miss_valid),
  .miss_addr(miss_addr), .flush_act(flush_act), .buf_empty(buf_empty)
);

// File: tb/sim_stbuf_top.sv
module sim_stbuf_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_valid = 0, st_tag_hit = 0, ld_valid = 0, flush = 0;
  logic [AW-1:0] st_addr = 0, ld_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic [NB-1:0] st_be = 0;
  logic st_stall, miss_valid, ld_rvalid, arr_rd_en, arr_wr_en, buf_empty;
  logic [AW-1:0] miss_addr, arr_rd_addr, arr_wr_addr;
  logic [DW-1:0] ld_rdata, arr_wr_data;
  logic [DW-1:0] arr_rdata = 0;
  logic [NB-1:0] arr_wr_be;

  always #2 clk = ~clk;  // 250 MHz

  stbuf_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (.*);

  // Data array model: one-cycle read, read-before-write, byte writes
  logic [DW-1:0] arr [256];
  always_ff @(posedge clk) begin
    if (arr_rd_en) arr_rdata <= arr[arr_rd_addr];
    if (arr_wr_en)
      for (int b = 0; b < NB; b++)
        if (arr_wr_be[b]) arr[arr_wr_addr][8*b +: 8] <= arr_wr_data[8*b +: 8];
  end

  // Reference model
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [NB-1:0] b; } ent_t;
  ent_t q[$];
  logic [DW-1:0] refmem [256];
  bit   mflush = 0;
  bit   prev_rv = 0, prev_miss = 0;
  logic [DW-1:0] prev_rd = 0;
  logic [AW-1:0] prev_ma = 0;
  int   n_cmp = 0, n_bad = 0;
  string ctx = "";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, ctx, act, exp, $time);
    end
  endtask

  task automatic cyc(bit stv, logic [AW-1:0] sa, logic [DW-1:0] sd, logic [NB-1:0] sb,
                     bit sh, bit ldv, logic [AW-1:0] la, bit fl);
    int n;
    bit hit, match, fla, dnf, mrg, ff, drn, psh;
    logic [DW-1:0] val;
    ent_t e;
    @(negedge clk);
    st_valid = stv; st_addr = sa; st_data = sd; st_be = sb; st_tag_hit = sh;
    ld_valid = ldv; ld_addr = la; flush = fl;
    #1;
    n     = q.size();
    hit   = stv && sh;
    match = (n > 0) && (q[n-1].a == sa);
    fla   = fl || mflush;
    dnf   = (n > 0) && (!ldv || fla);
    mrg   = hit && match && !(n == 1 && dnf);
    ff    = hit && (n == DEPTH) && !mrg;
    drn   = dnf || ((n > 0) && ff);
    psh   = hit && !mrg && (n < DEPTH);
    // same-cycle outputs
    chk("R7/R10 stall", 64'(st_stall), 64'(ff));
    chk("R2/R3 write enable", 64'(arr_wr_en), 64'(drn));
    if (drn) begin
      chk("R3 oldest addr", 64'(arr_wr_addr), 64'(q[0].a));
      chk("R3 oldest data", 64'(arr_wr_data), 64'(q[0].d));
      chk("R3 oldest be", 64'(arr_wr_be), 64'(q[0].b));
    end
    chk("R9 empty", 64'(buf_empty), 64'(n == 0));
    // one-cycle-late outputs
    chk("R4 rvalid", 64'(ld_rvalid), 64'(prev_rv));
    if (prev_rv) chk("R4/R5 load data", 64'(ld_rdata), 64'(prev_rd));
    chk("R8 miss flag", 64'(miss_valid), 64'(prev_miss));
    if (prev_miss) chk("R8 miss addr", 64'(miss_addr), 64'(prev_ma));
    // load result from pre-store buffer and pre-write array
    val = refmem[la];
    foreach (q[i])
      if (q[i].a == la)
        for (int b = 0; b < NB; b++)
          if (q[i].b[b]) val[8*b +: 8] = q[i].d[8*b +: 8];
    prev_rv = ldv; prev_rd = val;
    prev_miss = stv && !sh; prev_ma = sa;
    // advance state
    if (drn) begin
      for (int b = 0; b < NB; b++)
        if (q[0].b[b]) refmem[q[0].a][8*b +: 8] = q[0].d[8*b +: 8];
      void'(q.pop_front());
    end
    if (mrg) begin
      e = q[q.size()-1];
      for (int b = 0; b < NB; b++)
        if (sb[b]) e.d[8*b +: 8] = sd[8*b +: 8];
      e.b = e.b | sb;
      q[q.size()-1] = e;
    end
    if (psh) begin
      e.a = sa; e.d = sd; e.b = sb;
      q.push_back(e);
    end
    mflush = fla && (q.size() != 0);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      arr[i]    = 32'hA5000000 ^ (i * 32'h00010203);
      refmem[i] = 32'hA5000000 ^ (i * 32'h00010203);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    ctx = "R1 reset";
    chk("R1 empty", 64'(buf_empty), 64'd1);
    chk("R1 stall", 64'(st_stall), 64'd0);
    chk("R1 write", 64'(arr_wr_en), 64'd0);
    chk("R1 miss", 64'(miss_valid), 64'd0);
    chk("R1 rvalid", 64'(ld_rvalid), 64'd0);

    // R2/R5: store and load to the same word in one cycle, load sees old data
    ctx = "R2 R5 same-cycle";
    cyc(1, 8'h10, 32'h11223344, 4'hF, 1, 1, 8'h10, 0);
    cyc(1, 8'h11, 32'h55667788, 4'hF, 1, 1, 8'h10, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h11, 0);
    idle(4);

    // R4: youngest entry wins per byte, other bytes from the array
    ctx = "R4 youngest";
    cyc(1, 8'h20, 32'h0000BBAA, 4'h3, 1, 1, 8'h00, 0);
    cyc(1, 8'h21, 32'hCAFEF00D, 4'hF, 1, 1, 8'h01, 0);
    cyc(1, 8'h20, 32'h00DDCC00, 4'h6, 1, 1, 8'h02, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h20, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h21, 0);
    idle(5);

    // R6: repeated stores to one word fold into a single entry
    ctx = "R6 merge";
    cyc(1, 8'h30, 32'h000000EE, 4'h1, 1, 1, 8'h00, 0);
    cyc(1, 8'h30, 32'h0000DD00, 4'h2, 1, 1, 8'h00, 0);
    cyc(1, 8'h30, 32'hCC000000, 4'h8, 1, 1, 8'h30, 0);
    cyc(1, 8'h31, 32'h12345678, 4'hF, 1, 1, 8'h30, 0);
    idle(4);

    // R7/R10: fill under constant loads, then stall with forced drain
    ctx = "R7 R10 full";
    for (int i = 0; i < 6; i++)
      cyc(1, 8'h40 + 8'(i), 32'h40000000 + i, 4'hF, 1, 1, 8'h40, 0);
    cyc(1, 8'h45, 32'h0000AB00, 4'h2, 1, 1, 8'h45, 0);
    idle(6);

    // R8: a tag miss is reported and not buffered
    ctx = "R8 miss";
    cyc(1, 8'h50, 32'hDEADBEEF, 4'hF, 0, 1, 8'h50, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h50, 0);
    idle(2);

    // R9: flush drains through a stream of loads
    ctx = "R9 flush";
    for (int i = 0; i < 3; i++)
      cyc(1, 8'h60 + 8'(i), 32'h60606060 + i, 4'hF, 1, 1, 8'h60, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h61, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, 8'h62, 0);

    // Mixed traffic over a few words
    ctx = "mixed R3 R4 R6 R7";
    for (int i = 0; i < 2000; i++)
      cyc($urandom_range(0, 3) != 0, 8'($urandom_range(0, 5)), $urandom,
          4'($urandom_range(1, 15)), $urandom_range(0, 9) != 0,
          $urandom_range(0, 2) != 0, 8'($urandom_range(0, 5)),
          $urandom_range(0, 60) == 0);
    ctx = "final drain R9";
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule